// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block lets software run PHY management transactions on one of several MDIO buses. Software first fills in a parameter word, a register address and a clock-rate setting. It then writes an opcode to a control register, polls a status bit until it reads 1, and for reads collects the result from a read-data register. Writing zero to the control register clears the done indication so that the next operation can be started.

The block builds the serial management clock from the core clock through a programmable phase timer. It shifts out Clause 22 frames, or a Clause 45 address frame followed by a Clause 45 data frame. On read frames it releases the data line and samples the returned bits. The parameter word chooses between an internal and an external group of buses and gives the bus index within the group. Only the chosen bus sees clock edges and driven data. A separate control bit reports to the surrounding logic that any external management master must stay off the buses.

The sequencer has three states. `ST_IDLE` waits for a start. The start transition goes to `ST_ADDR` for Clause 45 and to `ST_DATA` for Clause 22. `ST_ADDR` moves to `ST_DATA` at the end of its final clock slot. `ST_DATA` returns to `ST_IDLE` at the end of its final slot and sets the done flag in the same cycle.

Top module: `mdio_regmaster`

## Requirements
- R1: After reset the status word and the read-data word read 0. Every MDC and output-enable pin is low, and `ext_master_block` is 0. While no transaction runs, all MDC and output-enable pins stay low.
- R2: The word offsets are: 0 external rate, 1 internal rate, 2 scan control, 3 parameter, 4 read data, 5 address, 6 control, 7 status. The parameter word reads back all 32 bits. The address word reads back bits 20:0 and zeros above. A rate word reads back the divisor in bits 9:0 and the dividend in bits 19:16, with zeros elsewhere. Read data bits 31:16 read 0.
- R3: A control write acts only while the sequencer is idle. Value 1 starts a write and value 2 starts a read, and either one starts only if the done flag is 0. Value 0 clears the done flag. Any other value, and every control write made during a transaction, has no effect.
- R4: Status bit 0 is the done flag. It is 0 for the whole of a transaction and becomes 1 in the cycle in which the final MDC slot of the last frame ends.
- R5: A Clause 22 write sends 64 MDC slots MSB first, with the driver enabled throughout. The slots carry 32 ones, start 01, opcode 01, the PHY address (parameter bits 20:16), the register address (address bits 4:0), turnaround 10, and the data (parameter bits 15:0). Each bit is held for a whole slot, and a slot is a low MDC phase followed by a high phase.
- R6: A Clause 22 read uses opcode 10. The driver is enabled for the first 46 slots and released for the last 18. The block samples the data line on the rising MDC edge of each of the last 16 slots, MSB first, into read-data bits 15:0.
- R7: When parameter bit 21 is 1, a Clause 45 address frame is sent first: start 00, opcode 00, the PHY address, the device address (address bits 20:16), turnaround 10 and the register address (address bits 15:0). A data frame follows with start 00 and opcode 01 for a write or 11 for a read, with the same port and device fields.
- R8: Each MDC phase lasts max(1, floor(divisor*(dividend+1)/2)) core clocks. External buses take the divisor and dividend from the external rate word, and internal buses from the internal rate word.
- R9: Parameter bit 25 set selects the internal group and clear selects the external group. Bits 24:22 give the bus index. Only the selected bus receives MDC, data and output enable, and only its input is sampled.
- R10: Writes to the parameter, address or rate words during a transaction are ignored.
- R11: Bit 28 of the scan control word is the only stored bit of that word, and it drives `ext_master_block`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_master_block | output | 1 | External management master must stay off the buses |
| int_mdc | output | NBUS | Clock for each internal bus |
| int_mdo | output | NBUS | Data driven onto each internal bus |
| int_mdoe | output | NBUS | Output enable for each internal bus |
| int_mdi | input | NBUS | Data returned by each internal bus |
| ext_mdc | output | NBUS | Clock for each external bus |
| ext_mdo | output | NBUS | Data driven onto each external bus |
| ext_mdoe | output | NBUS | Output enable for each external bus |
| ext_mdi | input | NBUS | Data returned by each external bus |

## Verification
The hardest situation to reach from the ports is register and control traffic that arrives while a frame is already in flight, because software normally waits for done before it touches anything. The bench starts a write and waits a few dozen cycles into the preamble. It then rewrites the parameter, address and both rate words, writes a clear and a read opcode to control, and lets the frame finish. The scoreboard must then see exactly the frame that was queued, timed at the original rate, and the readbacks must show the old values. A start attempted while done is still set is also tried, and no new frame may appear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA
    } seq_state_t;

    localparam int FRAME_W      = 64;
    localparam int RELEASE_SLOT = 46;
    localparam int DATA_SLOT    = 48;

    localparam logic [2:0] OFS_RATE_EXT = 3'd0;
    localparam logic [2:0] OFS_RATE_INT = 3'd1;
    localparam logic [2:0] OFS_SCAN     = 3'd2;
    localparam logic [2:0] OFS_PARAM    = 3'd3;
    localparam logic [2:0] OFS_RDDATA   = 3'd4;
    localparam logic [2:0] OFS_ADDR     = 3'd5;
    localparam logic [2:0] OFS_CTRL     = 3'd6;
    localparam logic [2:0] OFS_STATUS   = 3'd7;

    // preamble, start, opcode, port, device/register, turnaround, payload
    function automatic logic [FRAME_W-1:0] make_frame(
        input logic        c45,
        input logic [1:0]  op,
        input logic [4:0]  port,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        make_frame = {32'hFFFF_FFFF, 1'b0, ~c45, op, port, dev, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int DVD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [15:0]      rx_data,
    output logic             start_wr,
    output logic             start_rd,
    output logic             clr_done,
    output logic             scan_block,
    output logic [15:0]      f_wdata,
    output logic [4:0]       f_phy,
    output logic             f_c45,
    output logic [2:0]       f_idx,
    output logic             f_int,
    output logic [20:0]      f_regsel,
    output logic [DIV_W-1:0] sel_div,
    output logic [DVD_W-1:0] sel_dvd
);

    logic [31:0]      param_q;
    logic [20:0]      addr_q;
    logic [DIV_W-1:0] div_ext_q, div_int_q;
    logic [DVD_W-1:0] dvd_ext_q, dvd_int_q;
    logic             scan_q;
    logic             cfg_we, ctrl_we;

    assign cfg_we  = we && !busy;
    assign ctrl_we = we && !busy && (addr == OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            param_q   <= '0;
            addr_q    <= '0;
            div_ext_q <= '0;
            dvd_ext_q <= '0;
            div_int_q <= '0;
            dvd_int_q <= '0;
            scan_q    <= 1'b0;
        end else if (cfg_we) begin
            unique case (addr)
                OFS_RATE_EXT: begin
                    div_ext_q <= wdata[DIV_W-1:0];
                    dvd_ext_q <= wdata[16 +: DVD_W];
                end
                OFS_RATE_INT: begin
                    div_int_q <= wdata[DIV_W-1:0];
                    dvd_int_q <= wdata[16 +: DVD_W];
                end
                OFS_SCAN:  scan_q  <= wdata[28];
                OFS_PARAM: param_q <= wdata;
                OFS_ADDR:  addr_q  <= wdata[20:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        start_wr = ctrl_we && !done && (wdata == 32'd1);
        start_rd = ctrl_we && !done && (wdata == 32'd2);
        clr_done = ctrl_we && (wdata == 32'd0);
        unique case (addr)
            OFS_RATE_EXT: rdata = 32'(dvd_ext_q) << 16 | 32'(div_ext_q);
            OFS_RATE_INT: rdata = 32'(dvd_int_q) << 16 | 32'(div_int_q);
            OFS_SCAN:     rdata = {3'b000, scan_q, 28'd0};
            OFS_PARAM:    rdata = param_q;
            OFS_RDDATA:   rdata = {16'd0, rx_data};
            OFS_ADDR:     rdata = {11'd0, addr_q};
            OFS_CTRL:     rdata = 32'd0;
            OFS_STATUS:   rdata = {31'd0, done};
            default:      rdata = 32'd0;
        endcase
    end

    assign scan_block = scan_q;
    assign f_wdata    = param_q[15:0];
    assign f_phy      = param_q[20:16];
    assign f_c45      = param_q[21];
    assign f_idx      = param_q[24:22];
    assign f_int      = param_q[25];
    assign f_regsel   = addr_q;
    assign sel_div    = param_q[25] ? div_int_q : div_ext_q;
    assign sel_dvd    = param_q[25] ? dvd_int_q : dvd_ext_q;

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int PW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] phase,
    output logic          mdc,
    output logic          mdc_rise,
    output logic          mdc_fall
);

    logic [PW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = run && (cnt_q == phase - PW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    assign mdc      = mdc_q;
    assign mdc_rise = wrap && !mdc_q;
    assign mdc_fall = wrap && mdc_q;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_wr,
    input  logic        start_rd,
    input  logic        clr_done,
    input  logic        c45,
    input  logic [4:0]  phy,
    input  logic [20:0] regsel,
    input  logic [15:0] wdata,
    input  logic        mdc_rise,
    input  logic        mdc_fall,
    input  logic        mdi,
    output logic        busy,
    output logic        mdo,
    output logic        mdoe,
    output logic        done,
    output logic [15:0] rdata
);

    seq_state_t         state_q, state_d;
    logic [FRAME_W-1:0] shift_q, next_q;
    logic [FRAME_W-1:0] addr_frm, data_frm;
    logic [5:0]         slot_q;
    logic               rd_q, done_q;
    logic [15:0]        rdata_q;
    logic               go, last_slot, frame_end;
    logic [1:0]         opc;

    assign go        = (state_q == ST_IDLE) && (start_wr || start_rd);
    assign last_slot = (slot_q == 6'(FRAME_W - 1));
    assign frame_end = mdc_fall && last_slot;
    assign opc       = start_rd ? (c45 ? 2'b11 : 2'b10) : 2'b01;
    assign addr_frm  = make_frame(1'b1, 2'b00, phy, regsel[20:16], regsel[15:0]);
    assign data_frm  = make_frame(c45, opc, phy,
                                  c45 ? regsel[20:16] : regsel[4:0], wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)        state_d = c45 ? ST_ADDR : ST_DATA;
            ST_ADDR: if (frame_end) state_d = ST_DATA;
            ST_DATA: if (frame_end) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            next_q  <= '0;
            slot_q  <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (go) begin
                shift_q <= c45 ? addr_frm : data_frm;
                next_q  <= data_frm;
                slot_q  <= '0;
                rd_q    <= start_rd;
            end else if (mdc_fall) begin
                if (last_slot) begin
                    shift_q <= next_q;
                    slot_q  <= '0;
                end else begin
                    shift_q <= shift_q << 1;
                    slot_q  <= slot_q + 6'd1;
                end
            end
            if (mdc_rise && (state_q == ST_DATA) && rd_q && (slot_q >= 6'(DATA_SLOT)))
                rdata_q <= {rdata_q[14:0], mdi};
            if (clr_done)
                done_q <= 1'b0;
            else if ((state_q == ST_DATA) && frame_end)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        mdo   = busy && shift_q[FRAME_W-1];
        mdoe  = busy && !((state_q == ST_DATA) && rd_q && (slot_q >= 6'(RELEASE_SLOT)));
        done  = done_q;
        rdata = rdata_q;
    end

endmodule

// File: rtl/mdio_regmaster.sv
module mdio_regmaster
    import mdio_pkg::*;
#(
    parameter int NBUS  = 4,
    parameter int DIV_W = 10,
    parameter int DVD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            ext_master_block,
    output logic [NBUS-1:0] int_mdc,
    output logic [NBUS-1:0] int_mdo,
    output logic [NBUS-1:0] int_mdoe,
    input  logic [NBUS-1:0] int_mdi,
    output logic [NBUS-1:0] ext_mdc,
    output logic [NBUS-1:0] ext_mdo,
    output logic [NBUS-1:0] ext_mdoe,
    input  logic [NBUS-1:0] ext_mdi
);

    localparam int PW    = DIV_W + DVD_W;
    localparam int PRODW = PW + 1;

    logic             busy, done, start_wr, start_rd, clr_done;
    logic [15:0]      rx_data, f_wdata;
    logic [4:0]       f_phy;
    logic             f_c45, f_int;
    logic [2:0]       f_idx;
    logic [20:0]      f_regsel;
    logic [DIV_W-1:0] sel_div;
    logic [DVD_W-1:0] sel_dvd;
    logic [PRODW-1:0] prod;
    logic [PW-1:0]    half, phase;
    logic             mdc, mdc_rise, mdc_fall, mdo, mdoe;
    logic             mdi_sel;

    mdio_regfile #(.DIV_W(DIV_W), .DVD_W(DVD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done(done),
        .rx_data(rx_data), .start_wr(start_wr), .start_rd(start_rd),
        .clr_done(clr_done), .scan_block(ext_master_block),
        .f_wdata(f_wdata), .f_phy(f_phy), .f_c45(f_c45), .f_idx(f_idx),
        .f_int(f_int), .f_regsel(f_regsel), .sel_div(sel_div), .sel_dvd(sel_dvd)
    );

    always_comb begin
        prod  = PRODW'(sel_div) * (PRODW'(sel_dvd) + PRODW'(1));
        half  = PW'(prod >> 1);
        phase = (half == '0) ? PW'(1) : half;
    end

    mdio_clkgen #(.PW(PW)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .phase(phase),
        .mdc(mdc), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall)
    );

    mdio_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .clr_done(clr_done), .c45(f_c45), .phy(f_phy), .regsel(f_regsel),
        .wdata(f_wdata), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall),
        .mdi(mdi_sel), .busy(busy), .mdo(mdo), .mdoe(mdoe), .done(done),
        .rdata(rx_data)
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        logic hit_int, hit_ext;
        assign hit_int     = f_int && (f_idx == 3'(b));
        assign hit_ext     = !f_int && (f_idx == 3'(b));
        assign int_mdc[b]  = hit_int && mdc;
        assign int_mdo[b]  = hit_int && mdo;
        assign int_mdoe[b] = hit_int && mdoe;
        assign ext_mdc[b]  = hit_ext && mdc;
        assign ext_mdo[b]  = hit_ext && mdo;
        assign ext_mdoe[b] = hit_ext && mdoe;
    end

    always_comb begin
        mdi_sel = 1'b0;
        for (int b = 0; b < NBUS; b++) begin
            if (f_idx == 3'(b))
                mdi_sel = f_int ? int_mdi[b] : ext_mdi[b];
        end
    end

endmodule

// File: rtl/mdio_regmaster_chk.sv
module mdio_regmaster_chk #(
    parameter int NBUS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [15:0]     f_wdata,
    input logic [4:0]      f_phy,
    input logic [20:0]     f_regsel,
    input logic [NBUS-1:0] int_mdc,
    input logic [NBUS-1:0] ext_mdc,
    input logic [NBUS-1:0] int_mdoe,
    input logic [NBUS-1:0] ext_mdoe
);

    // R9
    one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_mdc, ext_mdc}));

    // R9
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_mdoe, ext_mdoe}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({int_mdc, ext_mdc, int_mdoe, ext_mdoe} == '0));

    // R4
    done_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R10
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(f_wdata) && $stable(f_phy) && $stable(f_regsel)));

endmodule

bind mdio_regmaster mdio_regmaster_chk #(.NBUS(NBUS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .f_wdata(f_wdata), .f_phy(f_phy), .f_regsel(f_regsel),
    .int_mdc(int_mdc), .ext_mdc(ext_mdc),
    .int_mdoe(int_mdoe), .ext_mdoe(ext_mdoe)
);

// File: tb/mdio_regmaster_tb.sv
module mdio_regmaster_tb;

    localparam int CLK_P = 10;
    localparam int NBUS  = 4;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        int          period;
        string       tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            ext_master_block;
    logic [NBUS-1:0] int_mdc, int_mdo, int_mdoe, int_mdi;
    logic [NBUS-1:0] ext_mdc, ext_mdo, ext_mdoe, ext_mdi;

    int    checks = 0, fails = 0, cyc = 0, frames = 0, stray = 0;
    bit    finished = 0;
    logic  tgt_ext = 0;
    int    tgt_idx = 0;
    logic  mdi_v = 1'b0;
    logic [63:0] rd_pat = '0;
    exp_t  exp_q[$];

    logic tmdc, tmdo, tmdoe;
    assign tmdc  = tgt_ext ? ext_mdc[tgt_idx]  : int_mdc[tgt_idx];
    assign tmdo  = tgt_ext ? ext_mdo[tgt_idx]  : int_mdo[tgt_idx];
    assign tmdoe = tgt_ext ? ext_mdoe[tgt_idx] : int_mdoe[tgt_idx];

    always_comb begin
        for (int b = 0; b < NBUS; b++) begin
            int_mdi[b] = (!tgt_ext && b == tgt_idx) ? mdi_v : 1'b1;
            ext_mdi[b] = ( tgt_ext && b == tgt_idx) ? mdi_v : 1'b1;
        end
    end

    mdio_regmaster #(.NBUS(NBUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_master_block(ext_master_block),
        .int_mdc(int_mdc), .int_mdo(int_mdo), .int_mdoe(int_mdoe), .int_mdi(int_mdi),
        .ext_mdc(ext_mdc), .ext_mdo(ext_mdo), .ext_mdoe(ext_mdoe), .ext_mdi(ext_mdi)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (({ext_mdc, int_mdc} & ~(64'(1) << (tgt_ext ? NBUS + tgt_idx : tgt_idx))) != '0)
            stray <= stray + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    int          rcnt = 0, t0 = 0, per = 0;
    logic [63:0] ob = '0, ooe = '0;
    always @(posedge tmdc) begin
        exp_t e;
        ob  = {ob[62:0], tmdo};
        ooe = {ooe[62:0], tmdoe};
        rcnt++;
        if (rcnt == 1) t0 = cyc;
        if (rcnt == 2) per = cyc - t0;
        if (rcnt == 64) begin
            rcnt = 0;
            frames++;
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected frame", ob, '0);
            end else begin
                e = exp_q.pop_front();
                check(((ob ^ e.bits) & e.oe) == '0, {e.tag, " frame bits"}, ob, e.bits);
                check(ooe == e.oe, {e.tag, " R6 drive enable pattern"}, ooe, e.oe);
                check(per == e.period, {e.tag, " R8 MDC period"}, 64'(per), 64'(e.period));
            end
        end
    end

    always @(negedge tmdc) mdi_v = rd_pat[63 - rcnt];

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [63:0] frm(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] p, input logic [4:0] d,
                                        input logic [15:0] data);
        frm = {32'hFFFF_FFFF, st, op, p, d, 2'b10, data};
    endfunction

    // driver: program registers and queue the expected frames
    task automatic setup_op(input bit ext, input int idx, input bit c45, input bit rdop,
                            input logic [4:0] phy, input logic [20:0] ad,
                            input logic [15:0] wd, input logic [15:0] rv,
                            input int dv, input int dd, input string tag);
        exp_t e;
        int ph;
        logic [31:0] rate = (32'(dd) << 16) | 32'(dv);
        ph = (dv * (dd + 1)) / 2;
        if (ph < 1) ph = 1;
        tgt_ext = ext; tgt_idx = idx;
        rd_pat = {48'd0, rv};
        wr(3'd0, ext ? rate : 32'd22);
        wr(3'd1, ext ? 32'd22 : rate);
        wr(3'd3, {6'd0, !ext, 3'(idx), c45, phy, wd});
        wr(3'd5, {11'd0, ad});
        e.period = 2 * ph;
        e.tag = tag;
        if (c45) begin
            e.bits = frm(2'b00, 2'b00, phy, ad[20:16], ad[15:0]);
            e.oe = '1;
            exp_q.push_back(e);
            e.bits = frm(2'b00, rdop ? 2'b11 : 2'b01, phy, ad[20:16], wd);
        end else begin
            e.bits = frm(2'b01, rdop ? 2'b10 : 2'b01, phy, ad[4:0], wd);
        end
        e.oe = rdop ? {{46{1'b1}}, 18'd0} : '1;
        exp_q.push_back(e);
        wr(3'd6, 32'd0);
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        int n = 0;
        do begin rd(3'd7, v); n++; end while (v[0] !== 1'b1 && n < 5000);
        check(v[0] === 1'b1, {tag, " R4 done reached"}, v, 1);
        check(exp_q.size() == 0, {tag, " all frames seen"}, 64'(exp_q.size()), 0);
        check(stray == 0, {tag, " R9 other buses quiet"}, 64'(stray), 0);
    endtask

    task automatic run_op(input bit ext, input int idx, input bit c45, input bit rdop,
                          input logic [4:0] phy, input logic [20:0] ad,
                          input logic [15:0] wd, input logic [15:0] rv,
                          input int dv, input int dd, input string tag);
        logic [31:0] v;
        setup_op(ext, idx, c45, rdop, phy, ad, wd, rv, dv, dd, tag);
        wr(3'd6, rdop ? 32'd2 : 32'd1);
        rd(3'd7, v);
        check(v == 0, {tag, " R4 done low while busy"}, v, 0);
        wait_done(tag);
        if (rdop) begin
            rd(3'd4, v);
            check(v == {16'd0, rv}, {tag, " R6 read data"}, v, {16'd0, rv});
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd7, v); check(v == 0, "R1 status after reset", v, 0);
        rd(3'd4, v); check(v == 0, "R1 read data after reset", v, 0);
        check({int_mdc, ext_mdc, int_mdoe, ext_mdoe, ext_master_block} == '0,
              "R1 pins idle", {int_mdc, ext_mdc, int_mdoe, ext_mdoe}, 0);

        // R2 readback masks, R11 override bit
        wr(3'd3, 32'hA5C3_1234); rd(3'd3, v); check(v == 32'hA5C3_1234, "R2 param", v, 32'hA5C3_1234);
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); check(v == 32'h001F_FFFF, "R2 address", v, 32'h001F_FFFF);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check(v == 32'h000F_03FF, "R2 rate", v, 32'h000F_03FF);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check(v == 32'h1000_0000, "R11 scan readback", v, 32'h1000_0000);
        check(ext_master_block == 1'b1, "R11 block set", 64'(ext_master_block), 1);
        wr(3'd2, 32'h0); check(ext_master_block == 1'b0, "R11 block clear", 64'(ext_master_block), 0);

        run_op(0, 1, 0, 0, 5'h05, 21'h12, 16'hBEEF, 16'h0, 4, 0, "R5 c22 write int1");
        run_op(1, 2, 0, 1, 5'h1F, 21'h03, 16'h0000, 16'h5A3C, 3, 1, "R6 c22 read ext2");
        run_op(0, 0, 1, 0, 5'h0A, {5'h07, 16'hC0DE}, 16'h1357, 16'h0, 1, 0, "R7 c45 write int0");
        run_op(1, 3, 1, 1, 5'h11, {5'h1E, 16'h0001}, 16'h0000, 16'h8001, 2, 2, "R7 c45 read ext3");

        // R10 / R3: writes during a transaction
        setup_op(0, 2, 0, 0, 5'h03, 21'h09, 16'h0F0F, 16'h0, 4, 1, "R10 busy writes");
        wr(3'd6, 32'd1);
        repeat (40) @(negedge clk);
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd5, 32'h0); wr(3'd0, 32'h5); wr(3'd1, 32'h5);
        wr(3'd6, 32'd0); wr(3'd6, 32'd2);
        wait_done("R10 busy writes");
        rd(3'd3, v); check(v == {6'd0, 1'b1, 3'd2, 1'b0, 5'h03, 16'h0F0F}, "R10 param kept", v, {6'd0, 1'b1, 3'd2, 1'b0, 5'h03, 16'h0F0F});
        rd(3'd5, v); check(v == 32'h9, "R10 address kept", v, 32'h9);
        rd(3'd1, v); check(v == 32'h0001_0004, "R10 rate kept", v, 32'h0001_0004);
        wr(3'd6, 32'd1);
        repeat (60) @(negedge clk);
        rd(3'd7, v); check(v == 1, "R3 start blocked by done", v, 1);
        check(frames == 7, "R3 no frame while done set", 64'(frames), 7);
        wr(3'd6, 32'd0);
        rd(3'd7, v); check(v == 0, "R3 zero clears done", v, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule